// File: doc/BRIEF.md
# Scrolling Word Seven-Segment Controller

This block drives a six-digit, time-multiplexed seven-segment display and scrolls the word "HELLO" across it from left to right. The display is treated as a ring of six slots: five letters and one blank slot. One scroll step moves the whole ring one digit to the right, and the letter that leaves the right edge comes back in at the left. Digit multiplexing never stops, whatever the scroll state.

After reset the display lights every segment for a fixed start-up interval and then goes dark. It waits there for a start command. Four single-cycle command pulses control scrolling at run time. Start begins scrolling or resumes it. Faster and slower move the step period through four levels. Pause freezes the window where it is. The commands arrive already debounced. With the default parameters and a 50 MHz clock, each digit is held for 1 ms, the start-up interval is 3 s and the step periods are 0.25 s, 0.5 s, 1 s and 2 s.

Top module: `scroll_marquee`

## Requirements
- R1: After reset, seg_n_o is 8'h00 for BOOT_TICKS cycles, and every command pulse in that interval has no effect. After that, seg_n_o is 8'hFF until a start pulse arrives.
- R2: In every cycle after reset, exactly one bit of dig_sel_n_o is low. The low bit index is the enabled digit, and digit 0 is the leftmost. The enabled digit starts at 0 and advances by one every SCAN_TICKS cycles, wrapping from 5 to 0. This continues in every mode.
- R3: While scrolling or paused, the enabled digit d at window position p shows ring slot (d - p) mod 6. The slots are, in order, H=8'h89, E=8'h86, L=8'hC7, L=8'hC7, O=8'hC0, blank=8'hFF. The segments are active low, with segment a in bit 0 through segment g in bit 6, and bit 7 is the point.
- R4: A start pulse while waiting blank sets p to 0 and restarts step timing. While running, p advances by one every period cycles and wraps from 5 to 0.
- R5: The period is QUARTER_TICKS shifted left by level. Level runs from 0 to 3 and is 2 after reset. Faster lowers the level and slower raises it, and both stop at the ends without wrapping. When faster and slower arrive in the same cycle, only faster applies. Any level change restarts the step count from zero.
- R6: A pause pulse while running freezes p and the partial step count, and the frozen content stays on the display. A step that falls in the same cycle as pause does not happen.
- R7: A start pulse while paused resumes scrolling from the frozen p and the frozen partial count. A pause pulse while waiting blank or already paused has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start or resume pulse |
| faster_i | input | 1 | Shorten step period pulse |
| slower_i | input | 1 | Lengthen step period pulse |
| pause_i | input | 1 | Freeze scrolling pulse |
| dig_sel_n_o | output | 6 | Active-low digit enable, bit 0 = leftmost |
| seg_n_o | output | 8 | Active-low segments, a in bit 0 to g in bit 6, point in bit 7 |

## Verification
Two events can land on the same edge: a step expiry of the scroll timer and a pause pulse (or a level change). The bench tracks the step count in its own model. It fires pause exactly in the cycle whose edge would advance the window, and it also fires faster and slower together. From then on it compares the shown glyph at every enabled digit against the frozen position it expects.

// File: rtl/mq_pkg.sv
package mq_pkg;
    localparam int NUM_DIGITS = 6;
    localparam int RING_LEN   = 6;
    localparam int POS_W      = 3;
    localparam int LEVEL_W    = 2;
    localparam int LEVEL_MAX  = 3;
    localparam int LEVEL_INIT = 2;

    typedef enum logic [1:0] {
        MODE_BOOT = 2'd0,
        MODE_IDLE = 2'd1,
        MODE_RUN  = 2'd2,
        MODE_HOLD = 2'd3
    } mode_e;

    localparam logic [7:0] SEG_ALL   = 8'h00;
    localparam logic [7:0] SEG_BLANK = 8'hFF;

    function automatic logic [7:0] slot_glyph(input logic [POS_W-1:0] slot);
        case (slot)
            3'd0:    slot_glyph = 8'h89;
            3'd1:    slot_glyph = 8'h86;
            3'd2:    slot_glyph = 8'hC7;
            3'd3:    slot_glyph = 8'hC7;
            3'd4:    slot_glyph = 8'hC0;
            default: slot_glyph = SEG_BLANK;
        endcase
    endfunction
endpackage

// File: rtl/mq_scan_timer.sv
module mq_scan_timer #(
    parameter int TICKS  = 50000,
    parameter int DIGITS = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    output logic [$clog2(DIGITS)-1:0] dig_o
);
    localparam int DIG_W = $clog2(DIGITS);
    localparam int CNT_W = $clog2(TICKS + 1);

    typedef struct packed {
        logic [DIG_W-1:0] dig;
        logic [CNT_W-1:0] cnt;
    } scan_t;

    scan_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.cnt == CNT_W'(TICKS - 1)) begin
            s_d.cnt = '0;
            s_d.dig = (s_q.dig == DIG_W'(DIGITS - 1)) ? '0 : s_q.dig + 1'b1;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign dig_o = s_q.dig;
endmodule

// File: rtl/mq_step_timer.sv
module mq_step_timer #(
    parameter int QUARTER_TICKS = 12500000
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      run_i,
    input  logic                      clear_i,
    input  logic [mq_pkg::LEVEL_W-1:0] level_i,
    output logic                      tick_o
);
    localparam int STEP_W = $clog2(QUARTER_TICKS * 8 + 1);
    localparam logic [STEP_W-1:0] QUARTER = STEP_W'(QUARTER_TICKS);

    logic [STEP_W-1:0] cnt_d, cnt_q;
    logic [STEP_W-1:0] period;

    always_comb begin
        period = QUARTER << level_i;
        tick_o = run_i && (cnt_q == period - 1'b1);
        cnt_d  = cnt_q;
        if (clear_i)     cnt_d = '0;
        else if (tick_o) cnt_d = '0;
        else if (run_i)  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/mq_glyph_dec.sv
module mq_glyph_dec
    import mq_pkg::*;
(
    input  mode_e                         mode_i,
    input  logic [$clog2(NUM_DIGITS)-1:0] dig_i,
    input  logic [POS_W-1:0]              pos_i,
    output logic [NUM_DIGITS-1:0]         sel_n_o,
    output logic [7:0]                    seg_n_o
);
    localparam int DIG_W = $clog2(NUM_DIGITS);

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_sel
        assign sel_n_o[i] = (dig_i != DIG_W'(i));
    end

    logic [POS_W:0] sum;
    logic [POS_W-1:0] slot;

    always_comb begin
        sum  = (POS_W+1)'(dig_i) + (POS_W+1)'(RING_LEN) - (POS_W+1)'(pos_i);
        slot = (sum >= (POS_W+1)'(RING_LEN)) ? POS_W'(sum - (POS_W+1)'(RING_LEN)) : POS_W'(sum);
        case (mode_i)
            MODE_BOOT: seg_n_o = SEG_ALL;
            MODE_IDLE: seg_n_o = SEG_BLANK;
            default:   seg_n_o = slot_glyph(slot);
        endcase
    end
endmodule

// File: rtl/scroll_marquee.sv
module scroll_marquee
    import mq_pkg::*;
#(
    parameter int SCAN_TICKS    = 50000,
    parameter int QUARTER_TICKS = 12500000,
    parameter int BOOT_TICKS    = 150000000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       faster_i,
    input  logic       slower_i,
    input  logic       pause_i,
    output logic [5:0] dig_sel_n_o,
    output logic [7:0] seg_n_o
);
    localparam int BOOT_W = $clog2(BOOT_TICKS + 1);
    localparam int DIG_W  = $clog2(NUM_DIGITS);

    typedef struct packed {
        mode_e               mode;
        logic [BOOT_W-1:0]   boot;
        logic [POS_W-1:0]    pos;
        logic [LEVEL_W-1:0]  level;
    } ctl_t;

    ctl_t c_d, c_q;
    logic step_tick;
    logic step_clear;
    logic [DIG_W-1:0] scan_dig;

    always_comb begin
        c_d        = c_q;
        step_clear = 1'b0;
        if (c_q.mode == MODE_BOOT) begin
            if (c_q.boot == BOOT_W'(BOOT_TICKS - 1)) c_d.mode = MODE_IDLE;
            else                                     c_d.boot = c_q.boot + 1'b1;
        end else begin
            if (faster_i) begin
                if (c_q.level != '0) begin
                    c_d.level  = c_q.level - 1'b1;
                    step_clear = 1'b1;
                end
            end else if (slower_i) begin
                if (c_q.level != LEVEL_W'(LEVEL_MAX)) begin
                    c_d.level  = c_q.level + 1'b1;
                    step_clear = 1'b1;
                end
            end

            if (pause_i && c_q.mode == MODE_RUN) begin
                c_d.mode = MODE_HOLD;
            end else if (start_i && c_q.mode == MODE_IDLE) begin
                c_d.mode   = MODE_RUN;
                c_d.pos    = '0;
                step_clear = 1'b1;
            end else if (start_i && c_q.mode == MODE_HOLD) begin
                c_d.mode = MODE_RUN;
            end

            if (c_q.mode == MODE_RUN && !pause_i && step_tick)
                c_d.pos = (c_q.pos == POS_W'(RING_LEN - 1)) ? '0 : c_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q.mode  <= MODE_BOOT;
            c_q.boot  <= '0;
            c_q.pos   <= '0;
            c_q.level <= LEVEL_W'(LEVEL_INIT);
        end else begin
            c_q <= c_d;
        end
    end

    mq_scan_timer #(
        .TICKS  (SCAN_TICKS),
        .DIGITS (NUM_DIGITS)
    ) u_scan (
        .clk   (clk),
        .rst   (rst),
        .dig_o (scan_dig)
    );

    mq_step_timer #(
        .QUARTER_TICKS (QUARTER_TICKS)
    ) u_step (
        .clk     (clk),
        .rst     (rst),
        .run_i   (c_q.mode == MODE_RUN),
        .clear_i (step_clear),
        .level_i (c_q.level),
        .tick_o  (step_tick)
    );

    mq_glyph_dec u_dec (
        .mode_i  (c_q.mode),
        .dig_i   (scan_dig),
        .pos_i   (c_q.pos),
        .sel_n_o (dig_sel_n_o),
        .seg_n_o (seg_n_o)
    );
endmodule

// File: rtl/mq_checker.sv
module mq_checker
    import mq_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 faster,
    input logic                 slower,
    input logic [5:0]           sel_n,
    input logic [7:0]           seg_n,
    input mode_e                mode,
    input logic [POS_W-1:0]     pos,
    input logic [LEVEL_W-1:0]   level
);
    // R2
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(~sel_n) == 1);

    // R1
    boot_lit_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_BOOT) |-> (seg_n == 8'h00));

    // R1
    idle_dark_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_IDLE) |-> (seg_n == 8'hFF));

    // R6
    hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_HOLD && $past(mode) == MODE_HOLD) |-> $stable(pos));

    // R5
    lvl_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_BOOT && level == 2'd0 && faster) |=> (level == 2'd0));

    // R5
    lvl_ceil_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_BOOT && level == 2'd3 && slower && !faster) |=> (level == 2'd3));
endmodule

bind scroll_marquee mq_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .faster (faster_i),
    .slower (slower_i),
    .sel_n  (dig_sel_n_o),
    .seg_n  (seg_n_o),
    .mode   (c_q.mode),
    .pos    (c_q.pos),
    .level  (c_q.level)
);

// File: tb/scroll_marquee_bench.sv
module scroll_marquee_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SCAN  = 3;
    localparam int QUART = 5;
    localparam int BOOT  = 30;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 0, faster_i = 0, slower_i = 0, pause_i = 0;
    logic [5:0] dig_sel_n_o;
    logic [7:0] seg_n_o;

    int total = 0, bad = 0, cycles = 0;
    string phase = "R1";

    // reference model state (0 boot, 1 idle, 2 run, 3 hold)
    int m_mode, m_boot, m_pos, m_lvl, m_step, m_dig, m_scnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    scroll_marquee #(
        .SCAN_TICKS    (SCAN),
        .QUARTER_TICKS (QUART),
        .BOOT_TICKS    (BOOT)
    ) u_scroll_marquee (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .faster_i    (faster_i),
        .slower_i    (slower_i),
        .pause_i     (pause_i),
        .dig_sel_n_o (dig_sel_n_o),
        .seg_n_o     (seg_n_o)
    );

    function automatic logic [7:0] exp_glyph(int slot);
        case (slot)
            0: return 8'h89;
            1: return 8'h86;
            2: return 8'hC7;
            3: return 8'hC7;
            4: return 8'hC0;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] exp_seg(int mode, int dig, int pos);
        if (mode == 0) return 8'h00;
        if (mode == 1) return 8'hFF;
        return exp_glyph((dig - pos + 6) % 6);
    endfunction

    function automatic int period_of(int lvl);
        return QUART << lvl;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst) begin
            m_mode <= 0; m_boot <= 0; m_pos <= 0; m_lvl <= 2;
            m_step <= 0; m_dig <= 0; m_scnt <= 0;
        end else begin
            automatic int nmode = m_mode, npos = m_pos, nlvl = m_lvl, nstep = m_step;
            automatic bit clr = 0;
            automatic bit tick = (m_mode == 2) && (m_step == period_of(m_lvl) - 1);
            if (m_scnt == SCAN - 1) begin
                m_scnt <= 0;
                m_dig  <= (m_dig == 5) ? 0 : m_dig + 1;
            end else m_scnt <= m_scnt + 1;
            if (m_mode == 0) begin
                if (m_boot == BOOT - 1) nmode = 1;
                else m_boot <= m_boot + 1;
            end else begin
                if (faster_i) begin
                    if (m_lvl > 0) begin nlvl = m_lvl - 1; clr = 1; end
                end else if (slower_i) begin
                    if (m_lvl < 3) begin nlvl = m_lvl + 1; clr = 1; end
                end
                if (pause_i && m_mode == 2) nmode = 3;
                else if (start_i && m_mode == 1) begin nmode = 2; npos = 0; clr = 1; end
                else if (start_i && m_mode == 3) nmode = 2;
                if (m_mode == 2 && !pause_i && tick) npos = (m_pos + 1) % 6;
            end
            if (clr) nstep = 0;
            else if (tick) nstep = 0;
            else if (m_mode == 2) nstep = m_step + 1;
            m_mode <= nmode; m_pos <= npos; m_lvl <= nlvl; m_step <= nstep;
        end
    end

    // output comparison away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            automatic logic [5:0] es = ~(6'b1 << m_dig);
            automatic logic [7:0] eg = exp_seg(m_mode, m_dig, m_pos);
            check(dig_sel_n_o == es, "R2 digit select", {2'b0, dig_sel_n_o}, {2'b0, es});
            check(seg_n_o == eg, phase, seg_n_o, eg);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(input bit s, input bit f, input bit sl, input bit p);
        @(negedge clk); #1;
        start_i = s; faster_i = f; slower_i = sl; pause_i = p;
        @(negedge clk); #1;
        start_i = 0; faster_i = 0; slower_i = 0; pause_i = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234ABCD));
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1: commands during start-up are ignored; lit, then blank
        phase = "R1 boot/idle";
        pulse(1, 1, 0, 0);
        pulse(0, 0, 1, 1);
        idle(BOOT + 20);
        // R7: pause while blank has no effect
        phase = "R7 pause idle";
        pulse(0, 0, 0, 1);
        idle(20);
        // R4: start and scroll at default level
        phase = "R4 scroll";
        pulse(1, 0, 0, 0);
        idle(150);
        // R5: faster to floor and beyond, then slower to ceiling and beyond
        phase = "R5 levels";
        for (int i = 0; i < 4; i++) begin pulse(0, 1, 0, 0); idle(25); end
        idle(40);
        for (int i = 0; i < 5; i++) begin pulse(0, 0, 1, 0); idle(30); end
        idle(100);
        pulse(0, 1, 1, 0);
        idle(60);
        // R6: pause on the exact cycle of a step
        phase = "R6 pause on step";
        @(negedge clk);
        while (!(m_mode == 2 && m_step == period_of(m_lvl) - 2)) @(negedge clk);
        pulse(0, 0, 0, 1);
        idle(100);
        pulse(0, 0, 0, 1);
        idle(20);
        // R7: resume from frozen position
        phase = "R7 resume";
        pulse(1, 0, 0, 0);
        idle(120);
        // R3: random commands, glyph content checked every cycle
        phase = "R3 random";
        for (int i = 0; i < 3000; i++) begin
            automatic int r = $urandom % 100;
            @(negedge clk); #1;
            start_i  = (r < 3);
            faster_i = (r >= 3 && r < 6) || r == 99;
            slower_i = (r >= 6 && r < 10) || r == 99;
            pause_i  = (r >= 10 && r < 13);
        end
        @(negedge clk); #1;
        start_i = 0; faster_i = 0; slower_i = 0; pause_i = 0;
        idle(10);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule